// File: doc/BRIEF.md
# Alternate-Space Instruction-Cache Flush Gate

This block sits between the memory pipeline and the level-1 instruction cache. It checks each decoded load-alternate or store-alternate access that targets a cache-control address space. Every accepted access gets a one-cycle response that carries an exception class and a fault code. An access that passes every check, is a write, and targets the instruction-cache flush space (space number 0x67) starts a sequencer. The sequencer clears the valid bit of every cache line, one line index per clock.

Accesses are taken strictly one at a time through a valid/ready handshake. While a flush is running, ready stays low, so nothing is accepted and nothing is speculated. The operand address is used untranslated. Only its three low bits matter: they must be zero. The write data never has any effect. Read data is always zero. The little-endian mode bit has no effect on any output, because these accesses are always big-endian.

Top module: `alt_flush_gate`

## Requirements
- R1: `req_op` is coded 0 doubleword load, 1 extended-word load, 2 float-doubleword load, 3 doubleword store, 4 extended-word store, 5 float-doubleword store, 6 other load, 7 other store. Codes 6 and 7 give `rsp_exc`=1 (data-access) and `rsp_ftype`=0x08, whatever the space, privilege or address.
- R2: A legal opcode aimed at space 0x67 that is either a load (codes 0-2) or issued with `req_priv`=0 gives `rsp_exc`=1 and `rsp_ftype`=0x01. This takes precedence over misalignment.
- R3: A legal opcode with `req_vaddr[2:0]`≠0 and no R2 fault gives `rsp_exc`=2 (misaligned) and `rsp_ftype`=0x00. No fault gives `rsp_exc`=0 and `rsp_ftype`=0x00.
- R4: `rsp_valid` is high for exactly the one cycle that follows each accepted access (`req_valid` and `req_ready` both high at a clock edge).
- R5: A fault-free store to space 0x67 with any aligned address and any data drives `inv_valid` high for NUM_LINES consecutive cycles. This run starts in the same cycle as its response. `inv_index` counts 0, 1, …, NUM_LINES-1 during the run.
- R6: `flush_done` is high for exactly the one cycle after the last index. `req_ready` returns high in the cycle after that.
- R7: `req_ready` is low from the cycle after a flush is accepted until `flush_done` has dropped. A request, including another flush request, presented during that time is not taken, and it neither restarts nor extends the index run.
- R8: A faulted access, and a fault-free access to any other space, never raises `inv_valid`.
- R9: `rsp_rdata` is always zero. `req_le` and `req_wdata` change no output.
- R10: After reset, `req_ready`=1 and `rsp_valid`, `rsp_exc`, `inv_valid` and `flush_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take an access |
| req_op | input | 3 | Opcode class (see R1) |
| req_space | input | 8 | Alternate space number |
| req_vaddr | input | VA_W | Untranslated operand address |
| req_wdata | input | DATA_W | Store data (ignored) |
| req_priv | input | 1 | 1 = supervisor mode |
| req_le | input | 1 | Little-endian mode bit (ignored) |
| rsp_valid | output | 1 | Response for last accepted access |
| rsp_exc | output | 2 | 0 none, 1 data-access, 2 misaligned |
| rsp_ftype | output | 8 | Fault-type code |
| rsp_rdata | output | DATA_W | Load data (always zero) |
| inv_valid | output | 1 | Invalidate the line at `inv_index` |
| inv_index | output | IDX_W | Line index being cleared |
| flush_done | output | 1 | One-cycle pulse at end of a flush |

## Verification
Two events land in the same cycle. The response of an accepted flush store appears together with the first invalidation step at index 0, and the bench checks both in that cycle. A second overlap is a new request arriving while the sequencer is busy. The bench holds a further flush request, and then a bad-opcode request, on the inputs partway through a run and keeps them there into the done cycle. It then confirms that the index sequence runs to its end without a restart, that no response appears, and that ready stays low until `flush_done` has come and gone.

// File: rtl/alt_flush_pkg.sv
package alt_flush_pkg;

  typedef enum logic [2:0] {
    OP_LD_DW   = 3'd0,
    OP_LD_XW   = 3'd1,
    OP_LD_FDW  = 3'd2,
    OP_ST_DW   = 3'd3,
    OP_ST_XW   = 3'd4,
    OP_ST_FDW  = 3'd5,
    OP_LD_OTH  = 3'd6,
    OP_ST_OTH  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_ACCESS = 2'd1,
    EXC_ALIGN  = 2'd2
  } exc_e;

  localparam logic [7:0] FT_NONE  = 8'h00;
  localparam logic [7:0] FT_BADOP = 8'h08;
  localparam logic [7:0] FT_PERM  = 8'h01;

  function automatic logic op_is_store(input logic [2:0] op);
    return (op == OP_ST_DW) || (op == OP_ST_XW) || (op == OP_ST_FDW) || (op == OP_ST_OTH);
  endfunction

  function automatic logic op_is_legal(input logic [2:0] op);
    return op <= OP_ST_FDW;
  endfunction

endpackage

// File: rtl/alt_flush_legality.sv
module alt_flush_legality
  import alt_flush_pkg::*;
#(
  parameter int SPACE_W = 8,
  parameter logic [SPACE_W-1:0] FLUSH_SPACE = 8'h67
) (
  input  logic [2:0]         op,
  input  logic [SPACE_W-1:0] space,
  input  logic [2:0]         va_low,
  input  logic               priv,
  output logic [1:0]         exc,
  output logic [7:0]         ftype,
  output logic               flush_go
);
  logic legal, to_flush, perm_bad, misal;

  always_comb begin
    legal    = op_is_legal(op);
    to_flush = (space == FLUSH_SPACE);
    perm_bad = to_flush && (!op_is_store(op) || !priv);
    misal    = (va_low != 3'b000);
    exc      = EXC_NONE;
    ftype    = FT_NONE;
    flush_go = 1'b0;
    if (!legal) begin
      exc   = EXC_ACCESS;
      ftype = FT_BADOP;
    end else if (perm_bad) begin
      exc   = EXC_ACCESS;
      ftype = FT_PERM;
    end else if (misal) begin
      exc   = EXC_ALIGN;
    end else begin
      flush_go = to_flush;
    end
  end
endmodule

// File: rtl/alt_flush_seq.sv
module alt_flush_seq #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             idle,
  output logic             inv_valid,
  output logic [IDX_W-1:0] inv_index,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

  st_e              st;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            st  <= S_RUN;
            idx <= '0;
          end
        end
        S_RUN: begin
          if (idx == LAST) begin
            st   <= S_DONE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          done <= 1'b0;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  assign idle      = (st == S_IDLE);
  assign inv_valid = (st == S_RUN);
  assign inv_index = idx;
endmodule

// File: rtl/alt_flush_resp.sv
module alt_flush_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [1:0]        exc_in,
  input  logic [7:0]        ftype_in,
  output logic              rsp_valid,
  output logic [1:0]        rsp_exc,
  output logic [7:0]        rsp_ftype,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_exc   <= 2'd0;
      rsp_ftype <= 8'h00;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_rdata <= '0;
      if (accept) begin
        rsp_exc   <= exc_in;
        rsp_ftype <= ftype_in;
      end
    end
  end
endmodule

// File: rtl/alt_flush_gate.sv
module alt_flush_gate #(
  parameter int VA_W = 64,
  parameter int DATA_W = 64,
  parameter int SPACE_W = 8,
  parameter logic [SPACE_W-1:0] FLUSH_SPACE = 8'h67,
  parameter int NUM_LINES = 64,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [SPACE_W-1:0] req_space,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_priv,
  input  logic               req_le,
  output logic               rsp_valid,
  output logic [1:0]         rsp_exc,
  output logic [7:0]         rsp_ftype,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               inv_valid,
  output logic [IDX_W-1:0]   inv_index,
  output logic               flush_done
);
  logic       accept, seq_idle, flush_go;
  logic [1:0] exc_c;
  logic [7:0] ft_c;
  logic       unused_inputs;

  assign unused_inputs = ^{req_wdata, req_le, req_vaddr[VA_W-1:3]};
  assign req_ready     = seq_idle;
  assign accept        = req_valid && seq_idle;

  alt_flush_legality #(.SPACE_W(SPACE_W), .FLUSH_SPACE(FLUSH_SPACE)) u_legal (
    .op(req_op), .space(req_space), .va_low(req_vaddr[2:0]), .priv(req_priv),
    .exc(exc_c), .ftype(ft_c), .flush_go(flush_go)
  );

  alt_flush_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .accept(accept), .exc_in(exc_c), .ftype_in(ft_c),
    .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_ftype(rsp_ftype), .rsp_rdata(rsp_rdata)
  );

  alt_flush_seq #(.NUM_LINES(NUM_LINES)) u_seq (
    .clk(clk), .rst(rst), .start(accept && flush_go), .idle(seq_idle),
    .inv_valid(inv_valid), .inv_index(inv_index), .done(flush_done)
  );
endmodule

// File: rtl/alt_flush_gate_chk.sv
module alt_flush_gate_chk #(
  parameter int DATA_W = 64,
  parameter int NUM_LINES = 64,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_exc,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              inv_valid,
  input logic [IDX_W-1:0]  inv_index,
  input logic              flush_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

  p_resp_follows_accept_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);
  p_resp_needs_accept_r4: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);
  p_index_steps_r5: assert property (@(posedge clk) disable iff (rst)
    inv_valid && (inv_index != LAST) |=> inv_valid && (inv_index == $past(inv_index) + 1'b1));
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    inv_valid && (inv_index == LAST) |=> flush_done && !inv_valid);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done && req_ready);
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (inv_valid || flush_done) |-> !req_ready);
  p_no_flush_on_fault_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_exc != 2'd0) |-> !inv_valid);
  p_rdata_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata == '0);
endmodule

bind alt_flush_gate alt_flush_gate_chk #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_rdata(rsp_rdata),
  .inv_valid(inv_valid), .inv_index(inv_index), .flush_done(flush_done)
);

// File: tb/alt_flush_gate_tb.sv
module alt_flush_gate_tb;
  localparam int NL = 16;
  localparam int IW = $clog2(NL);

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_priv = 0, req_le = 0;
  logic [2:0] req_op = 0;
  logic [7:0] req_space = 0;
  logic [63:0] req_vaddr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, inv_valid, flush_done;
  logic [1:0] rsp_exc;
  logic [7:0] rsp_ftype;
  logic [63:0] rsp_rdata;
  logic [IW-1:0] inv_index;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  alt_flush_gate #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_space(req_space), .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_priv(req_priv),
    .req_le(req_le), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_ftype(rsp_ftype),
    .rsp_rdata(rsp_rdata), .inv_valid(inv_valid), .inv_index(inv_index), .flush_done(flush_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkv(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // Drive one access while idle; returns at the negedge where its response is visible.
  task automatic send(input logic [2:0] op, input logic [7:0] sp, input logic [63:0] va,
                      input logic [63:0] wd, input logic pv, input logic le);
    @(negedge clk);
    req_valid = 1; req_op = op; req_space = sp; req_vaddr = va;
    req_wdata = wd; req_priv = pv; req_le = le;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_resp(input string req, input logic [1:0] exc, input logic [7:0] ft);
    chkv("R4", "rsp_valid", rsp_valid, 1);
    chkv(req, "rsp_exc", rsp_exc, exc);
    chkv(req, "rsp_ftype", rsp_ftype, ft);
    chkv("R9", "rsp_rdata", rsp_rdata, 0);
    chkv("R8", "inv_valid", inv_valid, 0);
    @(negedge clk);
    chkv("R4", "rsp_valid single", rsp_valid, 0);
    chkv("R8", "inv_valid later", inv_valid, 0);
    chkv("R8", "ready", req_ready, 1);
  endtask

  // Called at the response negedge of a flush store. hold_at >= 0 presents a competing request.
  task automatic run_flush(input int hold_at);
    chkv("R5", "rsp_exc flush", rsp_exc, 0);
    chkv("R4", "rsp_valid flush", rsp_valid, 1);
    for (int i = 0; i < NL; i++) begin
      chkv("R5", "inv_valid", inv_valid, 1);
      chkv("R5", "inv_index", inv_index, i);
      chkv("R7", "ready busy", req_ready, 0);
      if (i > 0) chkv("R7", "no rsp busy", rsp_valid, 0);
      if (hold_at >= 0 && i == hold_at) begin
        req_valid = 1; req_op = 3'd4; req_space = 8'h67; req_vaddr = 0; req_priv = 1;
      end
      if (hold_at >= 0 && i == hold_at + 2) req_op = 3'd7;
      @(negedge clk);
    end
    chkv("R6", "flush_done", flush_done, 1);
    chkv("R6", "inv_valid off", inv_valid, 0);
    chkv("R7", "ready in done", req_ready, 0);
    chkv("R7", "no rsp done", rsp_valid, 0);
    req_valid = 0;
    @(negedge clk);
    chkv("R6", "flush_done pulse", flush_done, 0);
    chkv("R6", "ready back", req_ready, 1);
    chkv("R7", "no restart", inv_valid, 0);
    chkv("R7", "no late rsp", rsp_valid, 0);
  endtask

  task automatic t_reset;
    chkv("R10", "ready", req_ready, 1);
    chkv("R10", "rsp_valid", rsp_valid, 0);
    chkv("R10", "rsp_exc", rsp_exc, 0);
    chkv("R10", "inv_valid", inv_valid, 0);
    chkv("R10", "flush_done", flush_done, 0);
  endtask

  task automatic t_bad_op;
    send(3'd7, 8'h67, 64'h5, 64'hFFFF, 0, 0); expect_resp("R1", 1, 8'h08);
    send(3'd6, 8'h20, 64'h0, 64'h0, 1, 1);    expect_resp("R1", 1, 8'h08);
  endtask

  task automatic t_perm;
    send(3'd0, 8'h67, 64'h0, 64'h0, 1, 0);    expect_resp("R2", 1, 8'h01);
    send(3'd4, 8'h67, 64'h3, 64'h1, 0, 0);    expect_resp("R2", 1, 8'h01);
    send(3'd2, 8'h67, 64'h6, 64'h0, 0, 1);    expect_resp("R2", 1, 8'h01);
  endtask

  task automatic t_align;
    send(3'd3, 8'h67, 64'h5, 64'h1234, 1, 0); expect_resp("R3", 2, 8'h00);
    send(3'd1, 8'h20, 64'h3, 64'h0, 0, 0);    expect_resp("R3", 2, 8'h00);
  endtask

  task automatic t_other_space;
    send(3'd1, 8'h20, 64'h40, 64'hDEAD, 1, 1); expect_resp("R9", 0, 8'h00);
    send(3'd5, 8'h21, 64'h0, 64'hBEEF, 0, 0);  expect_resp("R8", 0, 8'h00);
  endtask

  task automatic t_flush_plain;
    send(3'd3, 8'h67, 64'hFFFF_FFFF_FFFF_FFF8, 64'hA5A5_5A5A_0F0F_F0F0, 1, 0);
    run_flush(-1);
    send(3'd5, 8'h67, 64'h0000_1230, 64'h0, 1, 1);
    run_flush(-1);
  endtask

  task automatic t_flush_busy;
    send(3'd4, 8'h67, 64'h8, 64'h77, 1, 0);
    run_flush(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_bad_op();
    t_perm();
    t_align();
    t_other_space();
    t_flush_plain();
    t_flush_busy();
    t_bad_op();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule